// File: doc/BRIEF.md
# Processor Run-Control Coprocessor

This block lets a host drive a small multi-cycle processor core over a command channel. The host sends one command at a time with a valid/ready handshake. Each command carries a 4-bit opcode, a 32-bit address and a 32-bit data word. The block answers every command with one response. A response carries a 32-bit data word, a 4-bit kind code and the command's address echoed back.

Through this channel the host can do four things:

- Read and write words in the instruction memory and the data memory, through one shared memory port.
- Stage a value in an argument register and copy it into the core's program counter.
- Start the core, either until it executes a stop instruction or for an exact number of cycles, and halt it at any time.
- Read two performance counters: cycles spent running and instructions retired.

When the core executes a stop instruction, the block halts the core and raises a level interrupt toward the host.

Opcodes:

| Code | Action |
|------|--------|
| 0 | Instruction memory write |
| 1 | Instruction memory read |
| 2 | Data memory write |
| 3 | Data memory read |
| 4 | Load the argument register from the data field |
| 5 | Copy the argument register into the program counter |
| 6 | Run until a stop instruction |
| 7 | Load the program counter from the address field, then run for a number of cycles taken from the argument register |
| 8 | Halt |
| 9 | Read the cycle count |
| 10 | Read the retired-instruction count |

Response kinds:

| Code | Meaning |
|------|---------|
| 0 | Acknowledge, with data 0 |
| 1 | Data |
| 2 | Error, with data 0 |

Top module: `cpu_runctl`

## Requirements
- R1: A memory command drives `mem_sel` from opcode bit 1 (0 selects instruction memory, 1 selects data memory) and `mem_we` from opcode bit 0 inverted. A write answers kind 0. A read answers kind 1 with the stored word, which arrives on `mem_rdata` one cycle after the request. Every response echoes the command address in `rsp_addr`.
- R2: Opcode 4 stores the data field in the argument register. Opcode 5 pulses `core_pc_load` for exactly one cycle, with `core_pc_value` equal to the argument register.
- R3: Opcode 6 holds `core_run` high until the cycle in which `core_stop_hit` is seen. `core_run` is low from the next cycle, and `host_irq` rises at the same time.
- R4: Opcode 7 loads the program counter from the address field and holds `core_run` high for exactly as many cycles as the argument register holds. A value of 0 gives no run cycles. Reaching the end of the count raises no interrupt.
- R5: Opcode 8 drops `core_run` in either run mode and does not raise `host_irq`.
- R6: The cycle counter counts cycles with `core_run` high. The instruction counter counts `core_retire` pulses while running. Both clear on opcode 6 or 7 and hold while halted. Opcodes 9 and 10 return them with kind 1.
- R7: A memory command received while the core is running answers kind 2 with data 0, and the memory is left untouched.
- R8: `host_irq` is a level. It stays high across other commands until opcode 5, 6 or 7 clears it.
- R9: `cmd_ready` is low from the acceptance of a command until its response is taken. While `rsp_ready` is low, the response stays valid and unchanged.
- R10: Opcodes 11 to 15 answer kind 2 with data 0 and change neither the run state nor the interrupt.
- R11: After reset `core_run`, `host_irq` and `rsp_valid` are low, `cmd_ready` is high, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 32 | Command address field |
| cmd_data | input | 32 | Command data field |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 32 | Response data |
| rsp_kind | output | 4 | Response kind code |
| rsp_addr | output | 32 | Echoed command address |
| host_irq | output | 1 | Stop-instruction interrupt, level |
| core_run | output | 1 | Core may advance |
| core_pc_load | output | 1 | One-cycle program counter load strobe |
| core_pc_value | output | 32 | Program counter load value |
| core_retire | input | 1 | One-cycle pulse per retired instruction |
| core_stop_hit | input | 1 | Core is executing a stop instruction |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_sel | output | 1 | 0 instruction memory, 1 data memory |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |

## Verification
The hardest situations to reach from the ports are a memory command or a halt arriving while the core is running. Both need the core to stay busy across a full command round trip. The bench sets its core stub never to report a stop instruction, or loads a large bounded count, so the core keeps running. It then issues memory commands and a halt mid-run. Afterwards it reads the memory back and compares the counters with the run cycles it observed itself. A stalled response under backpressure is reached by holding `rsp_ready` low after a command is accepted.

// File: rtl/runctl_pkg.sv
package runctl_pkg;

    localparam int OP_W   = 4;
    localparam int KIND_W = 4;
    localparam int WORD_W = 32;

    typedef enum logic [OP_W-1:0] {
        OP_IMEM_WR = 4'd0,
        OP_IMEM_RD = 4'd1,
        OP_DMEM_WR = 4'd2,
        OP_DMEM_RD = 4'd3,
        OP_ARG_LD  = 4'd4,
        OP_ARG_PC  = 4'd5,
        OP_GO      = 4'd6,
        OP_GO_N    = 4'd7,
        OP_HALT    = 4'd8,
        OP_RD_CYC  = 4'd9,
        OP_RD_INS  = 4'd10
    } op_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_ACK  = 4'd0,
        KIND_DATA = 4'd1,
        KIND_ERR  = 4'd2
    } kind_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [KIND_W-1:0] kind;
        logic [WORD_W-1:0] addr;
    } rsp_t;

    // memory commands occupy opcodes 0..3
    function automatic logic op_is_mem(input logic [OP_W-1:0] op);
        return op[OP_W-1:2] == '0;
    endfunction

    // within memory commands, bit 0 marks a read
    function automatic logic op_is_read(input logic [OP_W-1:0] op);
        return op[0];
    endfunction

    // within memory commands, bit 1 selects data memory
    function automatic logic op_mem_sel(input logic [OP_W-1:0] op);
        return op[1];
    endfunction

    function automatic logic op_is_start(input logic [OP_W-1:0] op);
        return (op == OP_GO) || (op == OP_GO_N);
    endfunction

    function automatic logic op_defined(input logic [OP_W-1:0] op);
        return op <= OP_RD_INS;
    endfunction

endpackage

// File: rtl/runctl_perf.sv
module runctl_perf #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en && inc) begin
            count <= count + 1'b1;
        end
    end

    // R6
    perf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(count));

endmodule

// File: rtl/runctl_run.sv
module runctl_run
    import runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_valid,
    input  cmd_t              exec_cmd,
    input  logic              core_stop_hit,
    output logic              core_run,
    output logic              core_pc_load,
    output logic [WORD_W-1:0] core_pc_value,
    output logic              host_irq,
    output logic              cnt_clr
);

    logic [WORD_W-1:0] arg_q;
    logic [WORD_W-1:0] remain_q;
    logic              run_q;
    logic              bounded_q;
    logic              irq_q;
    logic              pc_load_q;
    logic [WORD_W-1:0] pc_val_q;

    assign cnt_clr = exec_valid && op_is_start(exec_cmd.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q     <= '0;
            remain_q  <= '0;
            run_q     <= 1'b0;
            bounded_q <= 1'b0;
            irq_q     <= 1'b0;
            pc_load_q <= 1'b0;
            pc_val_q  <= '0;
        end else begin
            pc_load_q <= 1'b0;
            // free-running behaviour of an active run
            if (run_q) begin
                if (core_stop_hit) begin
                    run_q <= 1'b0;
                    irq_q <= 1'b1;
                end else if (bounded_q && remain_q == 1) begin
                    run_q <= 1'b0;
                end
                if (bounded_q) begin
                    remain_q <= remain_q - 1'b1;
                end
            end
            // host commands take precedence
            if (exec_valid) begin
                case (exec_cmd.op)
                    OP_ARG_LD: arg_q <= exec_cmd.data;
                    OP_ARG_PC: begin
                        pc_load_q <= 1'b1;
                        pc_val_q  <= arg_q;
                        irq_q     <= 1'b0;
                    end
                    OP_GO: begin
                        run_q     <= 1'b1;
                        bounded_q <= 1'b0;
                        irq_q     <= 1'b0;
                    end
                    OP_GO_N: begin
                        pc_load_q <= 1'b1;
                        pc_val_q  <= exec_cmd.addr;
                        run_q     <= (arg_q != '0);
                        bounded_q <= 1'b1;
                        remain_q  <= arg_q;
                        irq_q     <= 1'b0;
                    end
                    OP_HALT: run_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign core_run      = run_q;
    assign core_pc_load  = pc_load_q;
    assign core_pc_value = pc_val_q;
    assign host_irq      = irq_q;

    // R3
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> $past(core_stop_hit && core_run));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_irq) |-> $past(exec_valid && (op_is_start(exec_cmd.op) || exec_cmd.op == OP_ARG_PC)));

endmodule

// File: rtl/runctl_cmd.sv
module runctl_cmd
    import runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  cmd_t              cmd_in,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output rsp_t              rsp_out,
    input  logic              core_busy,
    input  logic [WORD_W-1:0] cyc_val,
    input  logic [WORD_W-1:0] ins_val,
    output logic              exec_valid,
    output cmd_t              exec_cmd,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_sel,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);

    typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT, S_RESP} state_e;

    state_e state_q;
    cmd_t   cur_q;
    rsp_t   rsp_q;
    logic   mem_cmd;

    assign mem_cmd = op_is_mem(cur_q.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            rsp_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        cur_q   <= cmd_in;
                        state_q <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    rsp_q.addr <= cur_q.addr;
                    rsp_q.data <= '0;
                    rsp_q.kind <= KIND_ACK;
                    state_q    <= S_RESP;
                    if (mem_cmd) begin
                        if (core_busy) begin
                            rsp_q.kind <= KIND_ERR;
                        end else if (op_is_read(cur_q.op)) begin
                            state_q <= S_WAIT;
                        end
                    end else if (cur_q.op == OP_RD_CYC) begin
                        rsp_q.data <= cyc_val;
                        rsp_q.kind <= KIND_DATA;
                    end else if (cur_q.op == OP_RD_INS) begin
                        rsp_q.data <= ins_val;
                        rsp_q.kind <= KIND_DATA;
                    end else if (!op_defined(cur_q.op)) begin
                        rsp_q.kind <= KIND_ERR;
                    end
                end
                S_WAIT: begin
                    rsp_q.data <= mem_rdata;
                    rsp_q.kind <= KIND_DATA;
                    state_q    <= S_RESP;
                end
                default: begin
                    if (rsp_ready) begin
                        state_q <= S_IDLE;
                    end
                end
            endcase
        end
    end

    assign cmd_ready  = (state_q == S_IDLE);
    assign rsp_valid  = (state_q == S_RESP);
    assign rsp_out    = rsp_q;
    assign exec_valid = (state_q == S_EXEC);
    assign exec_cmd   = cur_q;
    assign mem_req    = (state_q == S_EXEC) && mem_cmd && !core_busy;
    assign mem_we     = !op_is_read(cur_q.op);
    assign mem_sel    = op_mem_sel(cur_q.op);
    assign mem_addr   = cur_q.addr;
    assign mem_wdata  = cur_q.data;

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_out)));

    // R9
    single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: rtl/cpu_runctl.sv
module cpu_runctl
    import runctl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [WORD_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic [KIND_W-1:0] rsp_kind,
    output logic [WORD_W-1:0] rsp_addr,
    output logic              host_irq,
    output logic              core_run,
    output logic              core_pc_load,
    output logic [WORD_W-1:0] core_pc_value,
    input  logic              core_retire,
    input  logic              core_stop_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_sel,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);

    cmd_t             cmd_bus;
    rsp_t             rsp_bus;
    logic             exec_valid;
    cmd_t             exec_cmd;
    logic             cnt_clr;
    logic [CNT_W-1:0] cyc_cnt;
    logic [CNT_W-1:0] ins_cnt;

    assign cmd_bus = '{op: cmd_op, addr: cmd_addr, data: cmd_data};
    assign rsp_data = rsp_bus.data;
    assign rsp_kind = rsp_bus.kind;
    assign rsp_addr = rsp_bus.addr;

    runctl_cmd i_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_in     (cmd_bus),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_out    (rsp_bus),
        .core_busy  (core_run),
        .cyc_val    (WORD_W'(cyc_cnt)),
        .ins_val    (WORD_W'(ins_cnt)),
        .exec_valid (exec_valid),
        .exec_cmd   (exec_cmd),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_sel    (mem_sel),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    runctl_run i_run (
        .clk           (clk),
        .rst           (rst),
        .exec_valid    (exec_valid),
        .exec_cmd      (exec_cmd),
        .core_stop_hit (core_stop_hit),
        .core_run      (core_run),
        .core_pc_load  (core_pc_load),
        .core_pc_value (core_pc_value),
        .host_irq      (host_irq),
        .cnt_clr       (cnt_clr)
    );

    runctl_perf #(.CNT_W(CNT_W)) i_cyc_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (core_run),
        .inc   (1'b1),
        .count (cyc_cnt)
    );

    runctl_perf #(.CNT_W(CNT_W)) i_ins_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (core_run),
        .inc   (core_retire),
        .count (ins_cnt)
    );

    // R7
    mem_while_run_chk: assert property (@(posedge clk) disable iff (rst)
        core_run |-> !mem_req);

endmodule

// File: tb/test_cpu_runctl.sv
module test_cpu_runctl;
    import runctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_data;
    logic [3:0]  rsp_kind;
    logic [31:0] rsp_addr;
    logic        host_irq;
    logic        core_run;
    logic        core_pc_load;
    logic [31:0] core_pc_value;
    logic        core_retire;
    logic        core_stop_hit;
    logic        mem_req;
    logic        mem_we;
    logic        mem_sel;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    cpu_runctl i_cpu_runctl (.*);

    // ---------------- stubs ----------------
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int mem_hits = 0;
    int stub_cnt = 0;
    int stop_at = 0;
    int run_seen = 0;
    int pc_pulses = 0;
    logic [31:0] pc_seen = '0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = '0;
            dmem[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (mem_req) begin
            mem_hits++;
            if (mem_we) begin
                if (mem_sel) dmem[mem_addr[7:2]] <= mem_wdata;
                else         imem[mem_addr[7:2]] <= mem_wdata;
            end else begin
                mem_rdata <= mem_sel ? dmem[mem_addr[7:2]] : imem[mem_addr[7:2]];
            end
        end
        stub_cnt <= core_run ? stub_cnt + 1 : 0;
        if (core_pc_load) pc_seen <= core_pc_value;
    end

    assign core_stop_hit = core_run && (stop_at != 0) && (stub_cnt == stop_at - 1);
    assign core_retire   = core_run && (stub_cnt % 3 == 2);

    always @(negedge clk) begin
        if (core_run)     run_seen++;
        if (core_pc_load) pc_pulses++;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [3:0]  kind;
        logic [31:0] data;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int n_vec = 0, n_bad = 0, mon_vec = 0, mon_bad = 0;

    always @(negedge clk) begin
        if (rsp_valid && rsp_ready) begin
            mon_vec++;
            if (sb.size() == 0) begin
                mon_bad++;
                $display("FAIL unexpected response act=%h exp=none", rsp_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_kind !== e.kind || rsp_data !== e.data || rsp_addr !== e.addr) begin
                    mon_bad++;
                    $display("FAIL %s act=kind %0d data %h addr %h exp=kind %0d data %h addr %h",
                             e.tag, rsp_kind, rsp_data, rsp_addr, e.kind, e.data, e.addr);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic present(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] ek, input logic [31:0] ed, input string tag);
        sb.push_back('{kind: ek, data: ed, addr: a, tag: tag});
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] ek, input logic [31:0] ed, input string tag);
        present(op, a, d, ek, ed, tag);
        drain();
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 3000 && core_run; i++) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        $display("FAIL watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec + mon_vec + 1, n_bad + mon_bad + 1);
        $finish;
    end

    // ---------------- stimulus ----------------
    int base, mbase, pbase, seen;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(core_run == 0, "R11 core_run", 64'(core_run), 0);
        chk(host_irq == 0, "R11 host_irq", 64'(host_irq), 0);
        chk(rsp_valid == 0, "R11 rsp_valid", 64'(rsp_valid), 0);
        chk(cmd_ready == 1, "R11 cmd_ready", 64'(cmd_ready), 1);
        send(OP_RD_CYC, 32'h0, 0, KIND_DATA, 0, "R11 cycle count");
        send(OP_RD_INS, 32'h4, 0, KIND_DATA, 0, "R11 instr count");

        // R1 memory access, separate memories
        send(OP_IMEM_WR, 32'h10, 32'hA5A5_0001, KIND_ACK, 0, "R1 imem wr");
        send(OP_DMEM_WR, 32'h10, 32'h5A5A_0002, KIND_ACK, 0, "R1 dmem wr");
        send(OP_IMEM_WR, 32'h3C, 32'h1234_5678, KIND_ACK, 0, "R1 imem wr hi");
        send(OP_IMEM_RD, 32'h10, 0, KIND_DATA, 32'hA5A5_0001, "R1 imem rd");
        send(OP_DMEM_RD, 32'h10, 0, KIND_DATA, 32'h5A5A_0002, "R1 dmem rd");
        send(OP_IMEM_RD, 32'h3C, 0, KIND_DATA, 32'h1234_5678, "R1 imem rd hi");
        send(OP_DMEM_RD, 32'h3C, 0, KIND_DATA, 32'h0, "R1 dmem rd untouched");

        // R2 staged PC load
        pbase = pc_pulses;
        send(OP_ARG_LD, 32'h0, 32'h100, KIND_ACK, 0, "R2 arg load");
        chk(pc_pulses == pbase, "R2 no pc load on arg", 64'(pc_pulses - pbase), 0);
        send(OP_ARG_PC, 32'h8, 0, KIND_ACK, 0, "R2 arg to pc");
        chk(pc_seen == 32'h100, "R2 pc value", 64'(pc_seen), 64'h100);
        chk(pc_pulses == pbase + 1, "R2 single pulse", 64'(pc_pulses - pbase), 1);

        // R3 run until stop instruction
        stop_at = 9;
        base = run_seen;
        send(OP_GO, 32'h0, 0, KIND_ACK, 0, "R3 start");
        wait_halt();
        chk(run_seen - base == 9, "R3 run cycles", 64'(run_seen - base), 9);
        chk(host_irq == 1, "R3 irq raised", 64'(host_irq), 1);
        send(OP_RD_CYC, 32'h0, 0, KIND_DATA, 9, "R6 cycles after stop");
        send(OP_RD_INS, 32'h0, 0, KIND_DATA, 3, "R6 instrs after stop");
        chk(host_irq == 1, "R8 irq held", 64'(host_irq), 1);
        send(OP_ARG_PC, 32'h0, 0, KIND_ACK, 0, "R8 arg to pc");
        chk(host_irq == 0, "R8 irq cleared by pc load", 64'(host_irq), 0);

        // R4 bounded run
        stop_at = 0;
        send(OP_ARG_LD, 32'h0, 20, KIND_ACK, 0, "R4 arg");
        base = run_seen;
        send(OP_GO_N, 32'h40, 0, KIND_ACK, 0, "R4 start n");
        wait_halt();
        repeat (3) @(negedge clk);
        chk(run_seen - base == 20, "R4 exact cycles", 64'(run_seen - base), 20);
        chk(pc_seen == 32'h40, "R4 pc from addr", 64'(pc_seen), 64'h40);
        chk(host_irq == 0, "R4 no irq on expiry", 64'(host_irq), 0);
        send(OP_RD_CYC, 32'h0, 0, KIND_DATA, 20, "R6 bounded cycles");
        send(OP_RD_INS, 32'h0, 0, KIND_DATA, 6, "R6 bounded instrs");
        send(OP_ARG_LD, 32'h0, 0, KIND_ACK, 0, "R4 arg zero");
        base = run_seen;
        send(OP_GO_N, 32'h80, 0, KIND_ACK, 0, "R4 start zero");
        repeat (5) @(negedge clk);
        chk(run_seen == base, "R4 zero count no run", 64'(run_seen - base), 0);
        send(OP_RD_CYC, 32'h0, 0, KIND_DATA, 0, "R6 cleared on start");

        // R7 and R5 memory while running, then halt
        base = run_seen;
        send(OP_GO, 32'h0, 0, KIND_ACK, 0, "R5 start open");
        mbase = mem_hits;
        send(OP_IMEM_WR, 32'h10, 32'hDEAD_BEEF, KIND_ERR, 0, "R7 write while running");
        send(OP_DMEM_RD, 32'h10, 0, KIND_ERR, 0, "R7 read while running");
        chk(mem_hits == mbase, "R7 memory untouched", 64'(mem_hits - mbase), 0);
        chk(core_run == 1, "R5 still running", 64'(core_run), 1);
        send(OP_HALT, 32'h0, 0, KIND_ACK, 0, "R5 halt");
        chk(core_run == 0, "R5 halted", 64'(core_run), 0);
        chk(host_irq == 0, "R5 no irq", 64'(host_irq), 0);
        seen = run_seen - base;
        repeat (5) @(negedge clk);
        chk(run_seen - base == seen, "R5 stays halted", 64'(run_seen - base), 64'(seen));
        send(OP_RD_CYC, 32'h0, 0, KIND_DATA, seen, "R6 cycles at halt");
        send(OP_IMEM_RD, 32'h10, 0, KIND_DATA, 32'hA5A5_0001, "R7 imem kept");

        // R5 halt during bounded run
        send(OP_ARG_LD, 32'h0, 1000, KIND_ACK, 0, "R5 arg large");
        base = run_seen;
        send(OP_GO_N, 32'h0, 0, KIND_ACK, 0, "R5 start n");
        repeat (5) @(negedge clk);
        send(OP_HALT, 32'h0, 0, KIND_ACK, 0, "R5 halt bounded");
        seen = run_seen - base;
        repeat (10) @(negedge clk);
        chk(core_run == 0 && run_seen - base == seen && seen < 1000, "R5 bounded halted",
            64'(run_seen - base), 64'(seen));

        // R8 start clears irq; R10 undefined opcodes
        stop_at = 4;
        send(OP_GO, 32'h0, 0, KIND_ACK, 0, "R8 start");
        wait_halt();
        chk(host_irq == 1, "R8 irq set", 64'(host_irq), 1);
        send(4'd12, 32'h20, 32'h7, KIND_ERR, 0, "R10 opcode 12");
        send(4'd15, 32'h24, 32'h7, KIND_ERR, 0, "R10 opcode 15");
        chk(host_irq == 1, "R10 irq unchanged", 64'(host_irq), 1);
        chk(core_run == 0, "R10 run unchanged", 64'(core_run), 0);
        stop_at = 0;
        send(OP_GO, 32'h0, 0, KIND_ACK, 0, "R8 restart");
        chk(host_irq == 0, "R8 irq cleared by start", 64'(host_irq), 0);
        send(4'd11, 32'h28, 0, KIND_ERR, 0, "R10 opcode 11");
        chk(core_run == 1, "R10 run kept", 64'(core_run), 1);
        send(OP_HALT, 32'h0, 0, KIND_ACK, 0, "R8 halt");

        // R9 backpressure and single outstanding command
        rsp_ready = 1'b0;
        present(OP_ARG_LD, 32'h44, 32'h9, KIND_ACK, 0, "R9 held response");
        repeat (3) @(negedge clk);
        chk(cmd_ready == 0, "R9 ready low while pending", 64'(cmd_ready), 0);
        chk(rsp_valid == 1, "R9 response held", 64'(rsp_valid), 1);
        chk(rsp_addr == 32'h44, "R9 response stable", 64'(rsp_addr), 64'h44);
        rsp_ready = 1'b1;
        drain();
        @(negedge clk);
        chk(cmd_ready == 1, "R9 ready after take", 64'(cmd_ready), 1);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R9 all responses seen", 64'(sb.size()), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec + mon_vec, n_bad + mon_bad);
        $finish;
    end

endmodule